// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up the synchronized input levels of a bank of GPIO pins before they reach the input-status readout and the interrupt edge detectors. Each pin has its own filter. A pin's filtered level moves to a new value only after the raw level has held that new value without interruption for a settling window. The window is measured in pulses of a shared 1 ms tick.

Each pin has its own enable and its own 4-bit rate code. The rate code is an exponent, so the window is 2^code tick pulses. Codes above the largest supported exponent saturate. When a pin's enable is low, its filter is bypassed and the filtered level simply follows the raw level.

When the controller is reset, every filtered output takes the pin's current raw level at once, with no settling window.

Top module: `gpio_debounce`

## Requirements
- R1: While `rst_n` is low, every clock edge loads each `pin_filt_o` bit with the matching `pin_raw_i` bit. After reset is released, that value holds until the filter rules below change it.
- R2: With `dbc_en_i[i]` low, `pin_filt_o[i]` equals the `pin_raw_i[i]` value sampled at the previous clock edge (default registered bypass).
- R3: With `dbc_en_i[i]` high, `pin_filt_o[i]` takes the raw value on the clock edge that samples the 2^c-th `tick_i` pulse during which the raw value has differed from the filtered value. Here c is the unsigned value of rate-code field `rate_code_i[4*i+3:4*i]`, for codes 0 to 7. It is unchanged before that edge.
- R4: If the raw level returns to the filtered level before the window completes, the count is cleared, and a later change needs a full new window.
- R5: Rate codes 8 to 15 behave exactly like code 7 (128 tick pulses).
- R6: A change of a pin's rate code while that pin is enabled clears that pin's count, so a full window of the new length is then needed.
- R7: With the filter enabled, `pin_filt_o[i]` changes only on a clock edge at which `tick_i` is high.
- R8: Each pin filters independently. Activity on one pin never changes another pin's output.
- R9: Tick pulses seen while the raw level equals the filtered level are not counted toward a later window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Shared 1 ms tick, one clock wide per pulse |
| pin_raw_i | input | NPINS | Synchronized raw pin levels |
| dbc_en_i | input | NPINS | Per-pin filter enable (0 = bypass) |
| rate_code_i | input | NPINS*4 | Per-pin 4-bit exponent; the field for pin i is bits [4*i+3:4*i] |
| pin_filt_o | output | NPINS | Filtered pin levels |

## Verification
A filtered change is due on the clock edge that samples the last needed tick pulse, and in bypass it is due one edge after the raw change. The bench drives every input on the falling edge and raises the tick for exactly one rising edge. It samples at the falling edge that follows, so each result is read half a cycle after the edge that produced it. Before the final tick of each window, the bench checks one idle clock and the first 2^c-1 pulses, to prove the output does not move early. The bounce, code-change and idle-tick cases each count pulses from the point where the count is cleared.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
   localparam int unsigned CODE_W = 4;

   // decoded window: last count index before the filtered value flips
   function automatic int unsigned window_last(input int unsigned code,
                                               input int unsigned max_code);
      int unsigned e;
      e = (code > max_code) ? max_code : code;
      return (32'd1 << e) - 32'd1;
   endfunction
endpackage

// File: rtl/gdb_rate_decode.sv
module gdb_rate_decode #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned MAX_CODE = 7,
   parameter int unsigned CNT_W    = 7
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  last_o
);
   logic [31:0] last_full;

   always_comb begin
      last_full = gdb_pkg::window_last(32'(code_i), MAX_CODE);
      last_o    = last_full[CNT_W-1:0];
   end
endmodule

// File: rtl/gdb_pin_filter.sv
module gdb_pin_filter #(
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned MAX_CODE   = 7,
   parameter bit          REG_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              raw_i,
   input  logic              en_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              filt_o
);
   localparam int unsigned CNT_W = MAX_CODE;

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last;
   logic [CODE_W-1:0] code_q;
   logic              filt_q;

   gdb_rate_decode #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .CNT_W(CNT_W)) u_dec (
      .code_i (code_i),
      .last_o (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filt_q <= raw_i;
         cnt_q  <= '0;
         code_q <= code_i;
      end else begin
         code_q <= code_i;
         if (!en_i) begin
            filt_q <= raw_i;
            cnt_q  <= '0;
         end else if (raw_i == filt_q || code_i != code_q) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            if (cnt_q >= last) begin
               filt_q <= raw_i;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   generate
      if (REG_BYPASS) begin : g_reg_bypass
         assign filt_o = filt_q;
         // R2
         bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i |=> filt_q == $past(raw_i));
      end else begin : g_comb_bypass
         assign filt_o = en_i ? filt_q : raw_i;
      end
   endgenerate

   // R7
   filt_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en_i) && filt_q != $past(filt_q)) |-> $past(tick_i));

   // R4
   stable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && raw_i == filt_q) |=> (cnt_q == '0 && filt_q == $past(filt_q)));

   // R6
   code_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && code_i != code_q) |=> cnt_q == '0);

   // R3
   hold_before_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !tick_i) |=> filt_q == $past(filt_q));
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
   parameter int unsigned NPINS      = 8,
   parameter int unsigned MAX_CODE   = 7,
   parameter bit          REG_BYPASS = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick_i,
   input  logic [NPINS-1:0]              pin_raw_i,
   input  logic [NPINS-1:0]              dbc_en_i,
   input  logic [NPINS*gdb_pkg::CODE_W-1:0] rate_code_i,
   output logic [NPINS-1:0]              pin_filt_o
);
   localparam int unsigned CW = gdb_pkg::CODE_W;

   generate
      if (NPINS < 1) begin : g_bad_npins
         $error("gpio_debounce: NPINS must be at least 1");
      end
      if (MAX_CODE < 1 || MAX_CODE > 15) begin : g_bad_max
         $error("gpio_debounce: MAX_CODE must be within 1..15");
      end

      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         gdb_pin_filter #(
            .CODE_W     (CW),
            .MAX_CODE   (MAX_CODE),
            .REG_BYPASS (REG_BYPASS)
         ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .raw_i  (pin_raw_i[i]),
            .en_i   (dbc_en_i[i]),
            .code_i (rate_code_i[i*CW +: CW]),
            .filt_o (pin_filt_o[i])
         );
      end
   endgenerate

   // R1
   reset_load_chk: assert property (@(posedge clk)
      !rst_n |=> pin_filt_o == $past(pin_raw_i));
endmodule

// File: tb/sim_gpio_debounce.sv
module sim_gpio_debounce;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [NP-1:0] raw = '0;
   logic [NP-1:0] en = '0;
   logic [NP*4-1:0] code = '0;
   logic [NP-1:0] filt;
   logic [NP-1:0] expv;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // pin, rate code, tick pulses needed
   localparam int VEC[7][3] = '{
      '{0, 0, 1}, '{1, 1, 2}, '{2, 2, 4}, '{3, 3, 8},
      '{4, 7, 128}, '{5, 9, 128}, '{6, 15, 128}};

   always #2.5 clk = ~clk;

   gpio_debounce u0 (
      .clk (clk), .rst_n (rst_n), .tick_i (tick), .pin_raw_i (raw),
      .dbc_en_i (en), .rate_code_i (code), .pin_filt_o (filt)
   );

   task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int k = 0; k < n; k++) pulse();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset loads raw every edge
      en = '1;
      for (int p = 0; p < NP; p++) code[p*4 +: 4] = 4'd2;
      raw = 8'h5A;
      repeat (2) @(negedge clk);
      check("R1 reset load", filt, 8'h5A);
      raw = 8'hC3;
      @(negedge clk);
      check("R1 reset reload", filt, 8'hC3);
      rst_n = 1'b1;
      pulse();
      check("R1 hold after release", filt, 8'hC3);
      expv = 8'hC3;

      // R2: bypass follows raw one edge later
      @(negedge clk) begin en = '0; raw = 8'h0F; end
      @(negedge clk);
      check("R2 bypass", filt, 8'h0F);
      @(negedge clk) en = '1;
      expv = 8'h0F;

      // R3 R5 R7 R8: table walk
      for (int v = 0; v < 7; v++) begin
         @(negedge clk) code[VEC[v][0]*4 +: 4] = 4'(VEC[v][1]);
         @(negedge clk) raw[VEC[v][0]] = ~raw[VEC[v][0]];
         @(negedge clk);
         check("R7 no change without tick", filt, expv);
         pulses(VEC[v][2] - 1);
         check((VEC[v][1] > 7) ? "R5 saturated window early" : "R3 window early R8", filt, expv);
         pulse();
         expv[VEC[v][0]] = ~expv[VEC[v][0]];
         check((VEC[v][1] > 7) ? "R5 saturated window end" : "R3 window end R8", filt, expv);
      end

      // R4: bounce clears count (pin 2, code 2 -> 4 pulses)
      @(negedge clk) raw[2] = ~raw[2];
      pulses(3);
      @(negedge clk) raw[2] = ~raw[2];
      @(negedge clk) raw[2] = ~raw[2];
      pulses(3);
      check("R4 bounce restarted", filt, expv);
      pulse();
      expv[2] = ~expv[2];
      check("R4 full window after bounce", filt, expv);

      // R9: idle ticks not counted (pin 3, code 1 -> 2 pulses)
      @(negedge clk) code[3*4 +: 4] = 4'd1;
      pulses(5);
      @(negedge clk) raw[3] = ~raw[3];
      pulse();
      check("R9 idle ticks not counted", filt, expv);
      pulse();
      expv[3] = ~expv[3];
      check("R9 window end", filt, expv);

      // R6: code change restarts (pin 1, code 3 then 2)
      @(negedge clk) code[1*4 +: 4] = 4'd3;
      @(negedge clk) raw[1] = ~raw[1];
      pulses(5);
      @(negedge clk) code[1*4 +: 4] = 4'd2;
      @(negedge clk);
      pulses(3);
      check("R6 restart after code change", filt, expv);
      pulse();
      expv[1] = ~expv[1];
      check("R6 new window end", filt, expv);

      finish_run();
   end
endmodule